// File: doc/BRIEF.md
# Triggered Word-Copy DMA Channel

This block is a single DMA channel that copies 32-bit words from a source address to a destination address. Software programs it through a flat, write-only register port. The registers hold the two addresses, a per-event word count, a cumulative total, a block interval with its prescaler, a fill word and a control word. A start-event vector from peripheral logic triggers the channel. On the master side it raises a request. Once granted, it issues one copy beat per cycle while the interconnect signals ready. Each beat carries the source address, the destination address, and a fill flag with its fill word.

Data moves in blocks of 2^n words. A block is never split: the request stays high from the grant until the last beat of the block. Between blocks the channel waits for an interval count, which ticks once every 1, 4, 16 or 64 clocks. The channel has three run modes:
- **Immediate** starts on enable.
- **Repeating** runs once for each selected event and stays enabled.
- **Counted** runs on each selected event and switches itself off once a cumulative total has been moved.

Each address can increment, decrement or hold. It can also reload its programmed value when an event's transfer ends. A fill source mode writes the fill word in place of a read.

Top module: `trig_dma_channel`

## Requirements
- R1: After reset, busy, mReq, mValid and irq are all low.
- R2: Register writes select by regIdx: 0 source address, 1 destination address, 2 total count (bits 27:0), 3 word count (bits 23:0), 4 interval (bits 15:0) with prescale code (bits 17:16), 5 fill word, 6 control. Writing index 0 or 1 also sets the working address, so the first beat carries the written value. Control bits are:
  - 11:10 destination step
  - 12 destination reload
  - 14:13 source step
  - 15 source reload
  - 19:16 block exponent
  - 27:24 event select
  - 28 immediate
  - 29 repeating
  - 30 irq enable
  - 31 enable, reported on busy
- R3: Step code 0 adds 4 to the address after each beat, code 1 subtracts 4, and code 2 holds it.
- R4: Source step code 3 is fill mode. Every beat has mFill high, mFillData carries the fill word, and the destination steps as usual.
- R5: With a reload bit set, that working address returns to its programmed value after the last beat of an event. With the bit clear, the next event continues from where the last one stopped.
- R6: A block holds min(2^exponent, words left) beats, and mReq does not drop inside a block.
- R7: Between blocks, mReq stays low for exactly interval × D cycles, where prescale codes 0, 1, 2 and 3 give D = 1, 4, 16 and 64. An interval of 0 gives no low cycle.
- R8: In immediate mode the word count is moved right after enable, and the total and repeating bits are ignored. Busy then clears.
- R9: In repeating mode the word count is moved on each selected event, and busy stays high.
- R10: In counted mode (neither immediate nor repeating) each event moves the word count, cut short at the remaining total. Busy clears on the beat that reaches the total, and events after that move nothing.
- R11: irq is a one-cycle pulse, gated by the irq-enable bit. It fires after an immediate transfer, after each repeating event, and after the final counted event only.
- R12: Only the start input chosen by the event select triggers the channel. Events that arrive while a transfer is in progress are dropped.
- R13: Register writes are ignored while the channel is requesting, bursting or waiting between blocks.
- R14: No beat is issued before mGrant. A beat completes only in a cycle with mValid and mReady both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| startEvt | input | 16 | Start event inputs |
| mReq | output | 1 | Bus request, held for a whole block |
| mGrant | input | 1 | Bus grant |
| mValid | output | 1 | Copy beat valid |
| mReady | input | 1 | Copy beat accepted |
| mSrcAddr | output | 32 | Beat source address |
| mDstAddr | output | 32 | Beat destination address |
| mFill | output | 1 | Beat writes fill data, no read |
| mFillData | output | 32 | Fill word |
| irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | Enable/busy bit |

## Verification
The embedded assertions check properties that must hold on every cycle:
- Blocks stay unbroken and no larger than 2^exponent.
- A beat becomes valid only after a grant.
- Incrementing destinations step by four, and reloads restore the programmed source.
- irq never lasts two cycles.
- Busy drops only on an accepted beat or a software write.

The directed scenarios cover the cases that need a picture of the whole transfer:
- the exact gap length for each prescale code;
- block truncation, fill data and decrement/hold addressing;
- the three run modes with their busy and irq outcomes;
- dropped events and register writes during a transfer.

// File: rtl/trig_dma_pkg.sv
package trig_dma_pkg;

  // register indices
  localparam int RIDX_SRC   = 0;
  localparam int RIDX_DST   = 1;
  localparam int RIDX_TOTAL = 2;
  localparam int RIDX_WORDS = 3;
  localparam int RIDX_GAP   = 4;
  localparam int RIDX_FILL  = 5;
  localparam int RIDX_CTRL  = 6;

  // control word bit positions
  localparam int CB_DST_MODE = 10;
  localparam int CB_DST_REL  = 12;
  localparam int CB_SRC_MODE = 13;
  localparam int CB_SRC_REL  = 15;
  localparam int CB_BLK      = 16;
  localparam int CB_EVT      = 24;
  localparam int CB_IMM      = 28;
  localparam int CB_REP      = 29;
  localparam int CB_IRQ      = 30;
  localparam int CB_EN       = 31;

  // gap register prescale position
  localparam int GB_PRE = 16;

  localparam logic [1:0] STEP_INC  = 2'd0;
  localparam logic [1:0] STEP_DEC  = 2'd1;
  localparam logic [1:0] STEP_HOLD = 2'd2;
  localparam logic [1:0] STEP_NONE = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_BURST,
    ST_GAP
  } chState_e;

  typedef struct packed {
    logic wrOk;       // registers may be written
    logic loadEvt;    // start of an event: load word counter
    logic loadBlk;    // grant seen: load block counter
    logic beat;       // one word accepted
    logic endEvt;     // this beat ends the event
    logic clrEnable;  // channel switches itself off
  } ctlStrobe_t;

endpackage

// File: rtl/trig_dma_datapath.sv
module trig_dma_datapath
  import trig_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WCNT_W    = 24,
  parameter int TOTAL_W   = 28,
  parameter int IVL_W     = 16,
  parameter int EVT_SEL_W = 4,
  parameter int BLK_EXP_W = 4,
  parameter int REG_W     = 32,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic [REG_W-1:0]     regWrData,
  input  ctlStrobe_t           ctl,
  output logic                 enable,
  output logic                 immMode,
  output logic                 repMode,
  output logic                 irqEn,
  output logic [EVT_SEL_W-1:0] evtSel,
  output logic [IVL_W-1:0]     intervalVal,
  output logic [1:0]           prescale,
  output logic [BLK_EXP_W-1:0] blkExp,
  output logic                 blkLast,
  output logic                 evtLast,
  output logic                 totalLast,
  output logic [ADDR_W-1:0]    srcAddr,
  output logic [ADDR_W-1:0]    dstAddr,
  output logic                 fillActive,
  output logic [REG_W-1:0]     fillData
);

  localparam int BLK_CNT_W  = 2 ** BLK_EXP_W;
  localparam int WORD_BYTES = 4;
  localparam int CMP_W      = 32;

  logic [ADDR_W-1:0]    srcProg, dstProg, srcWork, dstWork;
  logic [TOTAL_W-1:0]   totalCnt, totalLeft;
  logic [WCNT_W-1:0]    wordCnt, evtLeft;
  logic [BLK_CNT_W-1:0] blkLeft, blkLen;
  logic [1:0]           srcMode, dstMode;
  logic                 srcReload, dstReload, counted;
  logic                 wrSrc, wrDst, wrTotal, wrWords, wrGap, wrFill, wrCtrl;
  logic [CMP_W-1:0]     blkMax, lenA, lenB;

  assign wrSrc   = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_SRC));
  assign wrDst   = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_DST));
  assign wrTotal = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_TOTAL));
  assign wrWords = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_WORDS));
  assign wrGap   = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_GAP));
  assign wrFill  = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_FILL));
  assign wrCtrl  = regWrEn && ctl.wrOk && (regIdx == IDX_W'(RIDX_CTRL));

  assign counted = !immMode && !repMode;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a, input logic [1:0] mode);
    case (mode)
      STEP_INC: stepAddr = a + ADDR_W'(WORD_BYTES);
      STEP_DEC: stepAddr = a - ADDR_W'(WORD_BYTES);
      default:  stepAddr = a;
    endcase
  endfunction

  // programmed configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcProg     <= '0;
      dstProg     <= '0;
      totalCnt    <= '0;
      wordCnt     <= '0;
      intervalVal <= '0;
      prescale    <= '0;
      fillData    <= '0;
      dstMode     <= STEP_INC;
      dstReload   <= 1'b0;
      srcMode     <= STEP_INC;
      srcReload   <= 1'b0;
      blkExp      <= '0;
      evtSel      <= '0;
      immMode     <= 1'b0;
      repMode     <= 1'b0;
      irqEn       <= 1'b0;
      enable      <= 1'b0;
    end else begin
      if (wrSrc)   srcProg  <= {regWrData[ADDR_W-1:2], 2'b00};
      if (wrDst)   dstProg  <= {regWrData[ADDR_W-1:2], 2'b00};
      if (wrTotal) totalCnt <= regWrData[TOTAL_W-1:0];
      if (wrWords) wordCnt  <= regWrData[WCNT_W-1:0];
      if (wrGap) begin
        intervalVal <= regWrData[IVL_W-1:0];
        prescale    <= regWrData[GB_PRE +: 2];
      end
      if (wrFill) fillData <= regWrData;
      if (wrCtrl) begin
        dstMode   <= regWrData[CB_DST_MODE +: 2];
        dstReload <= regWrData[CB_DST_REL];
        srcMode   <= regWrData[CB_SRC_MODE +: 2];
        srcReload <= regWrData[CB_SRC_REL];
        blkExp    <= regWrData[CB_BLK +: BLK_EXP_W];
        evtSel    <= regWrData[CB_EVT +: EVT_SEL_W];
        immMode   <= regWrData[CB_IMM];
        repMode   <= regWrData[CB_REP];
        irqEn     <= regWrData[CB_IRQ];
        enable    <= regWrData[CB_EN];
      end else if (ctl.clrEnable) begin
        enable <= 1'b0;
      end
    end
  end

  // working addresses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcWork <= '0;
      dstWork <= '0;
    end else begin
      if (wrSrc) srcWork <= {regWrData[ADDR_W-1:2], 2'b00};
      else if (ctl.beat) srcWork <= (ctl.endEvt && srcReload) ? srcProg : stepAddr(srcWork, srcMode);
      if (wrDst) dstWork <= {regWrData[ADDR_W-1:2], 2'b00};
      else if (ctl.beat) dstWork <= (ctl.endEvt && dstReload) ? dstProg : stepAddr(dstWork, dstMode);
    end
  end

  // block length: power-of-two block cut to the words left
  always_comb begin
    blkMax = CMP_W'(1) << blkExp;
    lenA   = (CMP_W'(evtLeft) < blkMax) ? CMP_W'(evtLeft) : blkMax;
    lenB   = (counted && (CMP_W'(totalLeft) < lenA)) ? CMP_W'(totalLeft) : lenA;
    blkLen = BLK_CNT_W'(lenB);
  end

  // word counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalLeft <= '0;
      evtLeft   <= '0;
      blkLeft   <= '0;
    end else begin
      if (wrCtrl && regWrData[CB_EN]) totalLeft <= totalCnt;
      else if (ctl.beat && counted)   totalLeft <= totalLeft - 1'b1;
      if (ctl.loadEvt)   evtLeft <= wordCnt;
      else if (ctl.beat) evtLeft <= evtLeft - 1'b1;
      if (ctl.loadBlk)   blkLeft <= blkLen;
      else if (ctl.beat) blkLeft <= blkLeft - 1'b1;
    end
  end

  assign totalLast  = counted && (totalLeft == TOTAL_W'(1));
  assign evtLast    = (evtLeft == WCNT_W'(1)) || totalLast;
  assign blkLast    = (blkLeft == BLK_CNT_W'(1));
  assign srcAddr    = srcWork;
  assign dstAddr    = dstWork;
  assign fillActive = (srcMode == STEP_NONE);

  // R3
  dst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beat && !ctl.endEvt && dstMode == STEP_INC) |=> dstWork == $past(dstWork) + ADDR_W'(WORD_BYTES));

  // R5
  src_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beat && ctl.endEvt && srcReload) |=> srcWork == srcProg);

endmodule

// File: rtl/trig_dma_control.sv
module trig_dma_control
  import trig_dma_pkg::*;
#(
  parameter int IVL_W     = 16,
  parameter int EVT_NUM   = 16,
  parameter int EVT_SEL_W = 4,
  parameter int BLK_EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_NUM-1:0]   startEvt,
  input  logic                 mGrant,
  input  logic                 mReady,
  input  logic                 enable,
  input  logic                 immMode,
  input  logic                 repMode,
  input  logic                 irqEn,
  input  logic [EVT_SEL_W-1:0] evtSel,
  input  logic [IVL_W-1:0]     intervalVal,
  input  logic [1:0]           prescale,
  input  logic [BLK_EXP_W-1:0] blkExp,
  input  logic                 blkLast,
  input  logic                 evtLast,
  input  logic                 totalLast,
  output ctlStrobe_t           ctl,
  output logic                 mReq,
  output logic                 mValid,
  output logic                 irq
);

  localparam int PRE_W  = 6;
  localparam int BEAT_W = 2 ** BLK_EXP_W + 1;

  chState_e          state, stateNxt;
  logic [IVL_W-1:0]  gapCnt;
  logic [PRE_W-1:0]  preCnt, divMinus1;
  logic              tick, gapLoad, irqSet, evtHit;

  assign evtHit    = startEvt[evtSel];
  assign divMinus1 = (PRE_W'(1) << {prescale, 1'b0}) - PRE_W'(1);
  assign tick      = (preCnt == divMinus1);

  always_comb begin
    stateNxt      = state;
    ctl           = '0;
    ctl.wrOk      = (state == ST_IDLE);
    gapLoad       = 1'b0;
    irqSet        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (enable && (immMode || evtHit)) begin
          ctl.loadEvt = 1'b1;
          stateNxt    = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mGrant) begin
          ctl.loadBlk = 1'b1;
          stateNxt    = ST_BURST;
        end
      end
      ST_BURST: begin
        if (mReady) begin
          ctl.beat = 1'b1;
          if (evtLast) begin
            ctl.endEvt = 1'b1;
            stateNxt   = ST_IDLE;
            if (immMode || totalLast) begin
              ctl.clrEnable = 1'b1;
              irqSet        = irqEn;
            end else if (repMode) begin
              irqSet = irqEn;
            end
          end else if (blkLast) begin
            if (intervalVal == '0) begin
              stateNxt = ST_REQ;
            end else begin
              gapLoad  = 1'b1;
              stateNxt = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick && gapCnt == IVL_W'(1)) stateNxt = ST_REQ;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      irq    <= 1'b0;
      gapCnt <= '0;
      preCnt <= '0;
    end else begin
      state <= stateNxt;
      irq   <= irqSet;
      if (gapLoad) begin
        gapCnt <= intervalVal;
        preCnt <= '0;
      end else if (state == ST_GAP) begin
        if (tick) begin
          preCnt <= '0;
          gapCnt <= gapCnt - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  assign mReq   = (state == ST_REQ) || (state == ST_BURST);
  assign mValid = (state == ST_BURST);

  // checker: beats seen in the current block
  logic [BEAT_W-1:0] blkBeats;
  always_ff @(posedge clk) begin
    if (!rstN) blkBeats <= '0;
    else if (ctl.loadBlk) blkBeats <= '0;
    else if (ctl.beat) blkBeats <= blkBeats + 1'b1;
  end

  // R6
  blk_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.beat |-> (blkBeats < (BEAT_W'(1) << blkExp)));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mReq) |-> $past(mValid && mReady));

  // R14
  grant_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mValid) |-> $past(mGrant));

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

endmodule

// File: rtl/trig_dma_channel.sv
module trig_dma_channel
  import trig_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WCNT_W    = 24,
  parameter int TOTAL_W   = 28,
  parameter int IVL_W     = 16,
  parameter int EVT_NUM   = 16,
  parameter int BLK_EXP_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regIdx,
  input  logic [31:0]        regWrData,
  input  logic [EVT_NUM-1:0] startEvt,
  output logic               mReq,
  input  logic               mGrant,
  output logic               mValid,
  input  logic               mReady,
  output logic [ADDR_W-1:0]  mSrcAddr,
  output logic [ADDR_W-1:0]  mDstAddr,
  output logic               mFill,
  output logic [31:0]        mFillData,
  output logic               irq,
  output logic               busy
);

  localparam int EVT_SEL_W = (EVT_NUM > 1) ? $clog2(EVT_NUM) : 1;
  localparam int REG_W     = 32;
  localparam int IDX_W     = 3;

  ctlStrobe_t           ctl;
  logic                 enable, immMode, repMode, irqEn;
  logic                 blkLast, evtLast, totalLast;
  logic [EVT_SEL_W-1:0] evtSel;
  logic [IVL_W-1:0]     intervalVal;
  logic [1:0]           prescale;
  logic [BLK_EXP_W-1:0] blkExp;

  trig_dma_datapath #(
    .ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .TOTAL_W(TOTAL_W), .IVL_W(IVL_W),
    .EVT_SEL_W(EVT_SEL_W), .BLK_EXP_W(BLK_EXP_W), .REG_W(REG_W), .IDX_W(IDX_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .ctl(ctl), .enable(enable), .immMode(immMode), .repMode(repMode), .irqEn(irqEn),
    .evtSel(evtSel), .intervalVal(intervalVal), .prescale(prescale), .blkExp(blkExp),
    .blkLast(blkLast), .evtLast(evtLast), .totalLast(totalLast),
    .srcAddr(mSrcAddr), .dstAddr(mDstAddr), .fillActive(mFill), .fillData(mFillData)
  );

  trig_dma_control #(
    .IVL_W(IVL_W), .EVT_NUM(EVT_NUM), .EVT_SEL_W(EVT_SEL_W), .BLK_EXP_W(BLK_EXP_W)
  ) uControl (
    .clk(clk), .rstN(rstN), .startEvt(startEvt), .mGrant(mGrant), .mReady(mReady),
    .enable(enable), .immMode(immMode), .repMode(repMode), .irqEn(irqEn), .evtSel(evtSel),
    .intervalVal(intervalVal), .prescale(prescale), .blkExp(blkExp),
    .blkLast(blkLast), .evtLast(evtLast), .totalLast(totalLast),
    .ctl(ctl), .mReq(mReq), .mValid(mValid), .irq(irq)
  );

  assign busy = enable;

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(regWrEn)) |-> $past(mValid && mReady));

endmodule

// File: tb/tb_trig_dma_channel.sv
module tb_trig_dma_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [31:0] regWrData = '0;
  logic [15:0] startEvt = '0;
  logic        mReq, mValid, mFill, irq, busy;
  logic        mGrant = 1'b1;
  logic        mReady = 1'b1;
  logic [31:0] mSrcAddr, mDstAddr, mFillData;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  trig_dma_channel dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .startEvt(startEvt), .mReq(mReq), .mGrant(mGrant), .mValid(mValid), .mReady(mReady),
    .mSrcAddr(mSrcAddr), .mDstAddr(mDstAddr), .mFill(mFill), .mFillData(mFillData),
    .irq(irq), .busy(busy)
  );

  // beat monitor, away from the active edge
  int          beatCnt = 0;
  int          irqCnt = 0;
  int          lowRun = 0;
  logic [31:0] srcLog [0:255];
  logic [31:0] dstLog [0:255];
  logic [31:0] fdLog  [0:255];
  logic        fillLog [0:255];
  int          gapLog [0:255];

  always @(negedge clk) begin
    if (rstN && mValid && mReady) begin
      srcLog[beatCnt % 256]  = mSrcAddr;
      dstLog[beatCnt % 256]  = mDstAddr;
      fdLog[beatCnt % 256]   = mFillData;
      fillLog[beatCnt % 256] = mFill;
      gapLog[beatCnt % 256]  = lowRun;
      lowRun  = 0;
      beatCnt = beatCnt + 1;
    end else if (!mReq) begin
      lowRun = lowRun + 1;
    end
    if (irq) irqCnt = irqCnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(bit en, bit ie, bit rep, bit imm, int sel, int blk,
                                         bit sRel, int sMode, bit dRel, int dMode);
    logic [31:0] w;
    w = '0;
    w[31] = en; w[30] = ie; w[29] = rep; w[28] = imm;
    w[27:24] = sel[3:0]; w[19:16] = blk[3:0];
    w[15] = sRel; w[14:13] = sMode[1:0]; w[12] = dRel; w[11:10] = dMode[1:0];
    return w;
  endfunction

  task automatic wrReg(input int idx, input logic [31:0] val);
    @(posedge clk); #1;
    regWrEn = 1'b1; regIdx = idx[2:0]; regWrData = val;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(posedge clk); #1;
    startEvt[k] = 1'b1;
    @(posedge clk); #1;
    startEvt = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(mReq == 1'b0, "R1 mReq", mReq, 0);
    chk(mValid == 1'b0, "R1 mValid", mValid, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic tImmediate();
    int b = beatCnt;
    int q = irqCnt;
    wrReg(0, 32'h1000);
    wrReg(1, 32'h2000);
    wrReg(3, 5);
    wrReg(2, 1);
    wrReg(4, {14'd0, 2'd0, 16'd2});
    wrReg(6, mkCtrl(1, 1, 1, 1, 0, 2, 0, 0, 0, 0));
    settle(60);
    chk(beatCnt - b == 5, "R8 immediate beat count", beatCnt - b, 5);
    for (int i = 0; i < 5; i++) begin
      chk(srcLog[(b + i) % 256] == 32'h1000 + 4 * i, "R2 R3 source increment", srcLog[(b + i) % 256], 32'h1000 + 4 * i);
      chk(dstLog[(b + i) % 256] == 32'h2000 + 4 * i, "R2 R3 destination increment", dstLog[(b + i) % 256], 32'h2000 + 4 * i);
    end
    for (int i = 1; i < 4; i++)
      chk(gapLog[(b + i) % 256] == 0, "R6 no gap inside block", gapLog[(b + i) % 256], 0);
    chk(gapLog[(b + 4) % 256] == 2, "R6 R7 truncated second block after gap", gapLog[(b + 4) % 256], 2);
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    chk(irqCnt - q == 1, "R11 one irq", irqCnt - q, 1);
  endtask

  task automatic tStepModes();
    int b = beatCnt;
    wrReg(0, 32'h3000);
    wrReg(1, 32'h4000);
    wrReg(3, 3);
    wrReg(4, 0);
    wrReg(6, mkCtrl(1, 1, 0, 1, 0, 3, 0, 1, 0, 2));
    settle(20);
    chk(beatCnt - b == 3, "R3 beat count", beatCnt - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk(srcLog[(b + i) % 256] == 32'h3000 - 4 * i, "R3 source decrement", srcLog[(b + i) % 256], 32'h3000 - 4 * i);
      chk(dstLog[(b + i) % 256] == 32'h4000, "R3 destination hold", dstLog[(b + i) % 256], 32'h4000);
    end
  endtask

  task automatic tPrescale();
    for (int code = 0; code < 4; code++) begin
      int b = beatCnt;
      int d = 1 << (2 * code);
      wrReg(0, 32'h5000);
      wrReg(1, 32'h6000);
      wrReg(3, 2);
      wrReg(4, {14'd0, code[1:0], 16'd2});
      wrReg(6, mkCtrl(1, 0, 0, 1, 0, 0, 0, 0, 0, 0));
      settle(2 * d + 30);
      chk(beatCnt - b == 2, "R7 prescale beat count", beatCnt - b, 2);
      chk(gapLog[(b + 1) % 256] == 2 * d, "R7 prescaled gap", gapLog[(b + 1) % 256], 2 * d);
    end
  endtask

  task automatic tFill();
    int b = beatCnt;
    wrReg(5, 32'hCAFE_F00D);
    wrReg(0, 32'h7000);
    wrReg(1, 32'h8000);
    wrReg(3, 3);
    wrReg(4, 0);
    wrReg(6, mkCtrl(1, 1, 0, 1, 0, 1, 0, 3, 0, 0));
    settle(20);
    chk(beatCnt - b == 3, "R4 fill beat count", beatCnt - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk(fillLog[(b + i) % 256] == 1'b1, "R4 fill flag", fillLog[(b + i) % 256], 1);
      chk(fdLog[(b + i) % 256] == 32'hCAFE_F00D, "R4 fill word", fdLog[(b + i) % 256], 32'hCAFE_F00D);
      chk(dstLog[(b + i) % 256] == 32'h8000 + 4 * i, "R4 fill destination", dstLog[(b + i) % 256], 32'h8000 + 4 * i);
    end
  endtask

  task automatic tRepeat();
    int b = beatCnt;
    int q = irqCnt;
    wrReg(0, 32'h100);
    wrReg(1, 32'h800);
    wrReg(3, 3);
    wrReg(4, 0);
    wrReg(6, mkCtrl(1, 1, 1, 0, 5, 2, 1, 0, 0, 0));
    settle(5);
    chk(beatCnt - b == 0, "R9 waits for event", beatCnt - b, 0);
    pulse(4);
    settle(20);
    chk(beatCnt - b == 0, "R12 unselected event", beatCnt - b, 0);
    pulse(5);
    settle(20);
    chk(beatCnt - b == 3, "R9 first event beats", beatCnt - b, 3);
    chk(busy == 1'b1, "R9 busy stays", busy, 1);
    chk(irqCnt - q == 1, "R11 repeat irq", irqCnt - q, 1);
    mGrant = 1'b0;
    pulse(5);
    settle(3);
    pulse(5);
    mGrant = 1'b1;
    settle(20);
    chk(beatCnt - b == 6, "R12 event during transfer dropped", beatCnt - b, 6);
    chk(srcLog[(b + 3) % 256] == 32'h100, "R5 source reloaded", srcLog[(b + 3) % 256], 32'h100);
    chk(dstLog[(b + 3) % 256] == 32'h80C, "R5 destination continues", dstLog[(b + 3) % 256], 32'h80C);
    chk(irqCnt - q == 2, "R11 second repeat irq", irqCnt - q, 2);
    wrReg(6, mkCtrl(0, 1, 1, 0, 5, 2, 1, 0, 0, 0));
    settle(2);
    chk(busy == 1'b0, "R2 software disable", busy, 0);
  endtask

  task automatic tCounted();
    int b = beatCnt;
    int q = irqCnt;
    wrReg(0, 32'h9000);
    wrReg(1, 32'hA000);
    wrReg(3, 4);
    wrReg(2, 10);
    wrReg(4, 0);
    wrReg(6, mkCtrl(1, 1, 0, 0, 2, 3, 0, 0, 0, 0));
    pulse(2);
    settle(15);
    pulse(2);
    settle(15);
    chk(beatCnt - b == 8, "R10 two events", beatCnt - b, 8);
    chk(busy == 1'b1, "R10 busy before total", busy, 1);
    chk(irqCnt - q == 0, "R11 no irq before total", irqCnt - q, 0);
    pulse(2);
    settle(15);
    chk(beatCnt - b == 10, "R10 truncated at total", beatCnt - b, 10);
    chk(busy == 1'b0, "R10 busy cleared at total", busy, 0);
    chk(irqCnt - q == 1, "R11 irq at total", irqCnt - q, 1);
    pulse(2);
    settle(15);
    chk(beatCnt - b == 10, "R10 no move after total", beatCnt - b, 10);
  endtask

  task automatic tIrqGate();
    int b = beatCnt;
    int q = irqCnt;
    wrReg(3, 2);
    wrReg(6, mkCtrl(1, 0, 0, 1, 0, 2, 0, 0, 0, 0));
    settle(15);
    chk(beatCnt - b == 2, "R11 gated transfer beats", beatCnt - b, 2);
    chk(irqCnt - q == 0, "R11 irq gated off", irqCnt - q, 0);
    chk(busy == 1'b0, "R8 busy cleared gated", busy, 0);
  endtask

  task automatic tBusyWrites();
    int b = beatCnt;
    mGrant = 1'b0;
    wrReg(0, 32'hA000);
    wrReg(1, 32'hB000);
    wrReg(3, 3);
    wrReg(6, mkCtrl(1, 1, 0, 1, 0, 2, 0, 0, 0, 0));
    settle(10);
    chk(mReq == 1'b1, "R14 request raised", mReq, 1);
    chk(beatCnt - b == 0, "R14 no beat before grant", beatCnt - b, 0);
    wrReg(0, 32'hC000);
    wrReg(6, mkCtrl(0, 1, 0, 1, 0, 2, 0, 0, 0, 0));
    chk(busy == 1'b1, "R13 control write ignored", busy, 1);
    mReady = 1'b0;
    mGrant = 1'b1;
    settle(6);
    chk(beatCnt - b == 0, "R14 no beat without ready", beatCnt - b, 0);
    mReady = 1'b1;
    settle(20);
    chk(beatCnt - b == 3, "R14 beats after ready", beatCnt - b, 3);
    chk(srcLog[b % 256] == 32'hA000, "R13 source write ignored", srcLog[b % 256], 32'hA000);
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    settle(2);
    tReset();
    tImmediate();
    tStepModes();
    tPrescale();
    tFill();
    tRepeat();
    tCounted();
    tIrqGate();
    tBusyWrites();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule